// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key. It reuses a single round datapath once per clock. A request is one clock of `start` with `decrypt`, `data_in` and `key_in` valid. The engine first expands the key into all eleven round keys and stores them. It then applies the initial key addition and ten rounds. Encryption reads the stored keys upward from key 0. Decryption reads them downward from key 10. In both directions the last round leaves out the column-mixing step.

When the block is ready, `done` rises for one cycle and `result` holds it. `result` then stays unchanged until another request is accepted. While a request is in progress the engine takes no notice of `start`. A host therefore issues one request, waits for `done`, and may issue the next request on the following cycle.

Top module: `aes_iter_core`

## Requirements
- R1: Encryption gives the standard AES-128 ciphertext. Bits 127:120 of `data_in`, `key_in` and `result` hold byte 0, and bytes fill the 4x4 State column by column. Key 000102030405060708090a0b0c0d0e0f with block 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e151628aed2a6abf7158809cf4f3c with block 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32. The same key with block 6bc1bee22e409f96e93d7e117393172a gives 3ad77bb40d7a3660a89ecaf32466ef97.
- R2: With `decrypt`=1, each ciphertext listed in R1 decrypts under its key back to the matching plaintext.
- R3: `done` is high in the cycle that follows the 21st rising edge after the edge that accepted `start`. That is 10 key-expansion cycles, 1 whitening cycle and 10 round cycles.
- R4: `done` is a single-cycle pulse.
- R5: A `start` that arrives while an operation is in progress is ignored. The running operation keeps its original mode, block and key, and it keeps the latency of R3.
- R6: While idle without `start`, `result` holds its last value whatever `data_in`, `key_in` or `decrypt` do.
- R7: For any key and block, decrypting the encryption result returns the original block.
- R8: The key schedule stores round keys 0 to 10. Key 0 is the cipher key, and the round constants are 01,02,04,08,10,20,40,80,1b,36. Each expansion step writes one key, in ascending order, before the first round starts.
- R9: While reset is asserted and after its release, `done` is 0 and `result` is all zeros until the first completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, taken only when idle |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt, sampled with start |
| data_in | input | 128 | Input block, sampled with start |
| key_in | input | 128 | Cipher key, sampled with start |
| result | output | 128 | Output block, valid from done until the next accepted start |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is only meaningful as a single-cycle strobe. They also assume that the operand ports matter only in the cycle where a request is accepted. The hold and latency properties depend on both points. The bench raises `start` for exactly one cycle per request, and it drives stray strobes with altered operands only in the middle of a busy operation. After completion it changes the operand ports freely while `start` stays low.

// File: rtl/aes_pkg.sv
package aes_pkg;

  localparam int BLK_W  = 128;
  localparam int WORD_W = 32;
  localparam int NCOL   = BLK_W / WORD_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_KEYX  = 2'd1,
    PH_WHITE = 2'd2,
    PH_RND   = 2'd3
  } phase_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // a^254 = multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] a);
    logic [7:0] b;
    b = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    return gf_inv(b);
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox_fwd(w[31:24]), sbox_fwd(w[23:16]), sbox_fwd(w[15:8]), sbox_fwd(w[7:0])};
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3,
            gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3)};
  endfunction

  function automatic logic [31:0] unmix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_pkg::*;
#(
  parameter int NR = 10,
  localparam int NRK = NR + 1,
  localparam int CW = $clog2(NRK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [BLK_W-1:0]  key_in,
  input  logic [CW-1:0]     rd_idx,
  output logic [BLK_W-1:0]  rd_key
);

  logic [BLK_W-1:0] rk_q [NRK];
  logic [BLK_W-1:0] cur_q, cur_d;
  logic [7:0]       rcon_q, rcon_d;
  logic [CW-1:0]    widx_q, widx_d;
  logic [BLK_W-1:0] nxt_key;

  // one expansion step from the previous round key
  always_comb begin
    logic [WORD_W-1:0] w0, w1, w2, w3, t, n0, n1, n2, n3;
    {w0, w1, w2, w3} = cur_q;
    t  = sub_word({w3[23:0], w3[31:24]}) ^ {rcon_q, 24'h000000};
    n0 = w0 ^ t;
    n1 = w1 ^ n0;
    n2 = w2 ^ n1;
    n3 = w3 ^ n2;
    nxt_key = {n0, n1, n2, n3};
  end

  always_comb begin
    cur_d  = cur_q;
    rcon_d = rcon_q;
    widx_d = widx_q;
    if (load) begin
      cur_d  = key_in;
      rcon_d = 8'h01;
      widx_d = CW'(1);
    end else if (step) begin
      cur_d  = nxt_key;
      rcon_d = gf_x2(rcon_q);
      widx_d = widx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      rcon_q <= 8'h01;
      widx_q <= '0;
    end else begin
      cur_q  <= cur_d;
      rcon_q <= rcon_d;
      widx_q <= widx_d;
    end
  end

  for (genvar i = 0; i < NRK; i++) begin : g_rk
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rk_q[i] <= '0;
        else if (load) rk_q[i] <= key_in;
      end
    end else begin : g_rest
      logic we;
      assign we = step && (widx_q == CW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rk_q[i] <= '0;
        else if (we) rk_q[i] <= nxt_key;
      end
    end
  end

  assign rd_key = (rd_idx <= CW'(NR)) ? rk_q[rd_idx] : '0;

  // R8: the last expansion step uses the final round constant
  assert_rcon_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && widx_q == CW'(NR)) |-> (rcon_q == 8'h36));

  // R8: expansion steps only address stored keys 1..NR
  assert_step_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (widx_q >= CW'(1) && widx_q <= CW'(NR)));

  // R8: key 0 captures the cipher key on load
  assert_rk0_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rk_q[0] == $past(key_in)));

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] rkey,
  input  logic             dec,
  input  logic             last,
  output logic [BLK_W-1:0] nxt
);

  logic [7:0] in_b [NCOL*4];
  logic [7:0] f_sb [NCOL*4];
  logic [7:0] i_sb [NCOL*4];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign in_b[4*c+r] = st[BLK_W-1-8*(4*c+r) -: 8];
      // row r rotates left by r for encryption, right by r for decryption
      assign f_sb[4*c+r] = sbox_fwd(in_b[4*((c+r)%NCOL)+r]);
      assign i_sb[4*c+r] = sbox_inv(in_b[4*((c+NCOL-r)%NCOL)+r]);
    end

    logic [WORD_W-1:0] kw, f_col, f_out, i_col, i_out;
    assign kw    = rkey[BLK_W-1-WORD_W*c -: WORD_W];
    assign f_col = {f_sb[4*c], f_sb[4*c+1], f_sb[4*c+2], f_sb[4*c+3]};
    assign f_out = (last ? f_col : mix_col(f_col)) ^ kw;
    assign i_col = {i_sb[4*c], i_sb[4*c+1], i_sb[4*c+2], i_sb[4*c+3]} ^ kw;
    assign i_out = last ? i_col : unmix_col(i_col);
    assign nxt[BLK_W-1-WORD_W*c -: WORD_W] = dec ? i_out : f_out;
  end

endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_pkg::*;
#(
  parameter int NR = 10,
  localparam int CW  = $clog2(NR + 2),
  localparam int LAT = 2 * NR + 1,
  localparam int LW  = $clog2(LAT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              decrypt,
  input  logic [BLK_W-1:0]  data_in,
  input  logic [BLK_W-1:0]  key_in,
  output logic [BLK_W-1:0]  result,
  output logic              done
);

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_q   <= rs_meta;
    end
  end

  phase_e           ph_q, ph_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BLK_W-1:0] st_q, st_d;
  logic             mode_q, mode_d;
  logic             done_q, done_d;
  logic             ks_load, ks_step;
  logic [CW-1:0]    rd_idx;
  logic [BLK_W-1:0] rd_key, rnd_out;
  logic             last_rnd;

  assign last_rnd = (cnt_q == CW'(NR));

  aes_key_sched #(.NR(NR)) u_ks (
    .clk    (clk),
    .rst_n  (rst_q),
    .load   (ks_load),
    .step   (ks_step),
    .key_in (key_in),
    .rd_idx (rd_idx),
    .rd_key (rd_key)
  );

  aes_round_dp u_rnd (
    .st   (st_q),
    .rkey (rd_key),
    .dec  (mode_q),
    .last (last_rnd),
    .nxt  (rnd_out)
  );

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    st_d    = st_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    ks_load = 1'b0;
    ks_step = 1'b0;
    rd_idx  = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ks_load = 1'b1;
          st_d    = data_in;
          mode_d  = decrypt;
          cnt_d   = CW'(1);
          ph_d    = PH_KEYX;
        end
      end
      PH_KEYX: begin
        ks_step = 1'b1;
        if (cnt_q == CW'(NR)) ph_d = PH_WHITE;
        else                  cnt_d = cnt_q + CW'(1);
      end
      PH_WHITE: begin
        rd_idx = mode_q ? CW'(NR) : '0;
        st_d   = st_q ^ rd_key;
        cnt_d  = CW'(1);
        ph_d   = PH_RND;
      end
      PH_RND: begin
        rd_idx = mode_q ? (CW'(NR) - cnt_q) : cnt_q;
        st_d   = rnd_out;
        if (last_rnd) begin
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      st_q   <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      st_q   <= st_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign result = st_q;
  assign done   = done_q;

  // cycles since the accepting edge, watched by the latency property
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                      lat_q <= '0;
    else if (ph_q == PH_IDLE && start) lat_q <= '0;
    else if (ph_q != PH_IDLE)        lat_q <= lat_q + LW'(1);
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> (lat_q == LW'(LAT)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |=> !done_q);

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (ph_q != PH_IDLE) |=> $stable(mode_q));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (ph_q == PH_IDLE && !start) |=> $stable(result));

  assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (ph_q == PH_IDLE) |-> (done_q == $past(ph_q == PH_RND)));

endmodule

// File: tb/aes_iter_core_tb.sv
module aes_iter_core_tb;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         decrypt;
  logic [127:0] data_in;
  logic [127:0] key_in;
  logic [127:0] result;
  logic         done;

  int n_chk;
  int n_fail;
  int cyc;
  bit finished;

  localparam int EXP_LAT = 21;

  aes_iter_core u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .decrypt (decrypt),
    .data_in (data_in),
    .key_in  (key_in),
    .result  (result),
    .done    (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finish");
      report();
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one request; optional stray strobes at busy cycles 5 and 15 (R5)
  task automatic run_op(input bit m, input logic [127:0] k, input logic [127:0] d,
                        input bit poke, output logic [127:0] r, output int lat);
    @(negedge clk);
    start = 1'b1; decrypt = m; key_in = k; data_in = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (poke && (lat == 4 || lat == 14)) begin
        start = 1'b1; decrypt = ~m; key_in = ~k; data_in = ~d;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    r = result;
    @(negedge clk);
    check(done == 1'b0, "R4 done pulse width", {127'd0, done}, 128'd0);
  endtask

  logic [127:0] r;
  int lat;
  logic [63:0] seed;

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; data_in = '0; key_in = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result == '0, "R9 reset outputs", result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && result == '0, "R9 after release", result, 128'd0);

    // R1 / R3 / R8 known-answer encryption
    run_op(1'b0, 128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 1'b0, r, lat);
    check(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 enc vector A", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(lat == EXP_LAT, "R3 latency enc", 128'(lat), 128'(EXP_LAT));
    // R2 back to back
    run_op(1'b1, 128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, r, lat);
    check(r == 128'h00112233445566778899aabbccddeeff, "R2 dec vector A", r, 128'h00112233445566778899aabbccddeeff);
    check(lat == EXP_LAT, "R3 latency dec", 128'(lat), 128'(EXP_LAT));

    run_op(1'b0, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 1'b0, r, lat);
    check(r == 128'h3925841d02dc09fbdc118597196a0b32, "R1 enc vector B", r, 128'h3925841d02dc09fbdc118597196a0b32);
    run_op(1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32, 1'b0, r, lat);
    check(r == 128'h3243f6a8885a308d313198a2e0370734, "R2 dec vector B", r, 128'h3243f6a8885a308d313198a2e0370734);
    run_op(1'b0, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 1'b0, r, lat);
    check(r == 128'h3ad77bb40d7a3660a89ecaf32466ef97, "R1 enc vector C", r, 128'h3ad77bb40d7a3660a89ecaf32466ef97);
    run_op(1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3ad77bb40d7a3660a89ecaf32466ef97, 1'b0, r, lat);
    check(r == 128'h6bc1bee22e409f96e93d7e117393172a, "R2 dec vector C", r, 128'h6bc1bee22e409f96e93d7e117393172a);

    // R6 hold while idle with wandering inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      data_in = {4{32'(i) * 32'h9e3779b9}}; key_in = ~data_in; decrypt = i[0];
    end
    @(negedge clk);
    check(result == 128'h6bc1bee22e409f96e93d7e117393172a && done == 1'b0, "R6 idle hold", result, 128'h6bc1bee22e409f96e93d7e117393172a);

    // R5 stray starts while busy
    run_op(1'b0, 128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 1'b1, r, lat);
    check(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 busy start ignored", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(lat == EXP_LAT, "R5 latency unaffected", 128'(lat), 128'(EXP_LAT));
    run_op(1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32, 1'b1, r, lat);
    check(r == 128'h3243f6a8885a308d313198a2e0370734, "R5 busy start ignored dec", r, 128'h3243f6a8885a308d313198a2e0370734);

    // R7 round trip sweep over pseudo-random keys and blocks
    seed = 64'h0123456789abcdef;
    for (int i = 0; i < 24; i++) begin
      logic [127:0] k, p, c;
      seed = xs(seed); k[127:64] = seed;
      seed = xs(seed); k[63:0]   = seed;
      seed = xs(seed); p[127:64] = seed;
      seed = xs(seed); p[63:0]   = seed;
      if (i == 0) p = '0;
      if (i == 1) k = '1;
      run_op(1'b0, k, p, 1'b0, c, lat);
      check(c != p, "R7 ciphertext differs", c, p);
      run_op(1'b1, k, c, 1'b0, r, lat);
      check(r == p, "R7 round trip", r, p);
      check(lat == EXP_LAT, "R3 latency sweep", 128'(lat), 128'(EXP_LAT));
    end

    report();
  end

endmodule